// File: doc/BRIEF.md
# Pseudo-Static Memory Refresh Controller

This block is the refresh and row-arbitration logic inside a pseudo-static memory built on dynamic cells. It watches the external control pins on every clock tick and classifies them into an operating mode: read, write, row-touch refresh (an enabled, selected access with no read or write), deselected standby, pulse refresh, held self refresh and idle standby. It then decides which row the cell array opens next. It delivers the row as a single activation strobe with a row number and a flag that tells whether the row came from the external address or from the internal counter.

Three ways of keeping the cells alive share one internal row counter. An external access opens the row given by the low address bits, which are captured when the enable pin falls, and leaves the counter alone. Each interval in which the enable is high and the refresh pin is low starts with one counter refresh. If the refresh pin stays low past an entry threshold, a timer keeps issuing counter refreshes until the pin rises. Every activation keeps the array busy for a fixed number of ticks. Counter refreshes that are already waiting are served before a newly started external access. The array, the sense path and the data drivers sit outside the block. Only a data-drive flag comes out.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, no activation is issued. After reset the mode is idle (code 0), the data-drive flag is low and the first counter refresh uses row 0.
- R2: The mode code follows the pins. With enable low and select low it is 4, whatever the other pins show. With enable low and select high it is 2 when write is low, 1 when write is high and output-enable is low, and 3 when both are high. With enable high it is 0 when refresh is high, 5 for the first SELF_ENTER ticks of refresh low, and 6 after that.
- R3: The data-drive flag is high only in mode 1.
- R4: A falling enable with select high captures the low ROW_W address bits. It produces exactly one activation with the external flag set on that row, and the counter is left unchanged. A falling enable with select low produces no activation.
- R5: Each start of an interval with enable high and refresh low produces one counter activation. Counter activations use consecutive rows that wrap from 2^ROW_W-1 to 0.
- R6: Successive activations are at least ACT_LEN ticks apart.
- R7: Counter refreshes still waiting (up to 2^PEND_W-1 of them) are activated before an external access that starts after them.
- R8: From an idle array, a request seen in one cycle is activated on the second rising edge after it is first presented.
- R9: After SELF_ENTER ticks of refresh held low with enable high, a counter refresh is issued every SELF_PERIOD ticks. Issuing stops once refresh returns high.
- R10: Over 2^ROW_W self-refresh periods, every row is refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Access enable, active low; its falling edge starts an access |
| chip_sel | input | 1 | Select, active high; low deselects the device while enabled |
| out_en_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write command, active low |
| refresh_n | input | 1 | Refresh request, active low |
| addr_in | input | ADDR_W | External address; the low ROW_W bits pick the row |
| mode | output | 3 | Decoded operating mode code (see R2) |
| dout_en | output | 1 | Data bus drive flag |
| act_stb | output | 1 | Row activation strobe, one tick long |
| act_ext | output | 1 | Activated row came from the external address |
| act_row | output | ROW_W | Row being activated |

## Verification
Some properties are checked on every cycle. These are the minimum spacing between activations, the step-by-one order of counter rows, silence during and just after reset, the deselect override on the mode, the data-drive flag staying off while the device is not enabled, and the self mode never being shown unless the refresh pin was low with the device not enabled. Other behaviour needs the bench's scenarios. These include the captured external row, the counter being left alone by accesses, waiting refreshes going ahead of an access, the exact self-refresh cadence and its stop, and full row coverage with wrap over a long held refresh.

// File: rtl/psram_rfsh_pkg.sv
// Shared mode encoding for the refresh controller.
package psram_rfsh_pkg;
    typedef enum logic [2:0] {
        MD_IDLE   = 3'd0,
        MD_READ   = 3'd1,
        MD_WRITE  = 3'd2,
        MD_ROWHIT = 3'd3,
        MD_DESEL  = 3'd4,
        MD_PULSE  = 3'd5,
        MD_SELF   = 3'd6
    } mode_e;
endpackage

// File: rtl/psram_mode_dec.sv
// Mode decoder: turns the raw control pins plus the self-refresh state into
// a mode code and the data-drive flag. Purely combinational; assumes the pins
// are already synchronous to the controller clock.
module psram_mode_dec
    import psram_rfsh_pkg::*;
(
    input  logic  chip_en_n,
    input  logic  chip_sel,
    input  logic  out_en_n,
    input  logic  wr_n,
    input  logic  refresh_n,
    input  logic  in_self,
    output mode_e mode,
    output logic  dout_en
);
    // Priority decode: enable, then select, then write over read.
    always_comb begin
        if (!chip_en_n) begin
            if (!chip_sel)      mode = MD_DESEL;
            else if (!wr_n)     mode = MD_WRITE;
            else if (!out_en_n) mode = MD_READ;
            else                mode = MD_ROWHIT;
        end else if (refresh_n) begin
            mode = MD_IDLE;
        end else begin
            mode = in_self ? MD_SELF : MD_PULSE;
        end
    end

    // Drive data only for a read.
    always_comb dout_en = (mode == MD_READ);
endmodule

// File: rtl/psram_rfsh_sched.sv
// Refresh scheduler: raises a counter-refresh request at the start of every
// interval with enable high and refresh low, measures how long refresh stays
// low, and once past SELF_ENTER ticks issues a request every SELF_PERIOD
// ticks. Assumes SELF_ENTER >= 1 and SELF_PERIOD >= 2.
module psram_rfsh_sched #(
    parameter int SELF_ENTER  = 800,
    parameter int SELF_PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,      // enable high and refresh low this tick
    output logic in_self,
    output logic rf_req
);
    localparam int LOW_W = $clog2(SELF_ENTER + 1);
    localparam int TMR_W = $clog2(SELF_PERIOD + 1);

    logic             hold_q;
    logic [LOW_W-1:0] low_cnt;
    logic [TMR_W-1:0] tmr;
    logic             tick;

    assign in_self = (low_cnt == LOW_W'(SELF_ENTER));
    assign tick    = hold && in_self && (tmr == TMR_W'(SELF_PERIOD - 1));
    assign rf_req  = (hold && !hold_q) || tick;

    // Track the previous hold level for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold;
    end

    // Count held ticks, saturating at the self-refresh entry threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold)  low_cnt <= '0;
        else if (!in_self)    low_cnt <= low_cnt + 1'b1;
    end

    // Self-refresh period timer, running only while in self refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || !(hold && in_self)) tmr <= '0;
        else if (tick)                    tmr <= '0;
        else                              tmr <= tmr + 1'b1;
    end
endmodule

// File: rtl/psram_row_arb.sv
// Row arbiter: keeps a saturating count of waiting counter refreshes and one
// waiting external access, lets one activation through whenever the array is
// idle (counter refresh first), holds the array busy for ACT_LEN ticks after
// each activation, and owns the wrapping refresh row counter.
module psram_row_arb #(
    parameter int ROW_W   = 9,
    parameter int ACT_LEN = 4,
    parameter int PEND_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_req,
    input  logic             ext_start,
    input  logic [ROW_W-1:0] ext_row_in,
    output logic             act_stb,
    output logic             act_ext,
    output logic [ROW_W-1:0] act_row
);
    localparam int BUSY_W = $clog2(ACT_LEN + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend, pend_nxt;
    logic              ext_req;
    logic [ROW_W-1:0]  ext_row;
    logic [BUSY_W-1:0] busy;
    logic [ROW_W-1:0]  ctr;
    logic              idle, grant_rf, grant_ext;

    assign idle      = (busy == '0);
    assign grant_rf  = idle && (pend != '0);
    assign grant_ext = idle && (pend == '0) && ext_req;

    // Next waiting-refresh count: add a request, remove a grant, saturate.
    always_comb begin
        unique case ({rf_req, grant_rf})
            2'b10:   pend_nxt = (pend == PEND_MAX) ? pend : pend + 1'b1;
            2'b01:   pend_nxt = pend - 1'b1;
            default: pend_nxt = pend;
        endcase
    end

    // Waiting-refresh count register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // External access request and the row captured at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_req <= 1'b0;
            ext_row <= '0;
        end else if (ext_start) begin
            ext_req <= 1'b1;
            ext_row <= ext_row_in;
        end else if (grant_ext) begin
            ext_req <= 1'b0;
        end
    end

    // Busy window that spaces activations ACT_LEN ticks apart.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy <= '0;
        else if (grant_rf || grant_ext) busy <= BUSY_W'(ACT_LEN - 1);
        else if (!idle)              busy <= busy - 1'b1;
    end

    // Refresh row counter, advancing once per counter activation.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctr <= '0;
        else if (grant_rf) ctr <= ctr + 1'b1;
    end

    // Registered activation outputs toward the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_stb <= 1'b0;
            act_ext <= 1'b0;
            act_row <= '0;
        end else begin
            act_stb <= grant_rf || grant_ext;
            act_ext <= grant_ext;
            if (grant_rf)       act_row <= ctr;
            else if (grant_ext) act_row <= ext_row;
        end
    end
endmodule

// File: rtl/psram_refresh_ctrl.sv
// Refresh controller top: detects the falling enable that starts an access,
// decodes the mode, schedules counter refreshes, and arbitrates one row
// activation at a time. Assumes all pins are synchronous to clk.
module psram_refresh_ctrl
    import psram_rfsh_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int ROW_W       = 9,
    parameter int ACT_LEN     = 4,
    parameter int PEND_W      = 2,
    parameter int SELF_ENTER  = 800,
    parameter int SELF_PERIOD = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              chip_sel,
    input  logic              out_en_n,
    input  logic              wr_n,
    input  logic              refresh_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [2:0]        mode,
    output logic              dout_en,
    output logic              act_stb,
    output logic              act_ext,
    output logic [ROW_W-1:0]  act_row
);
    logic  en_n_q;
    logic  ext_start;
    logic  hold;
    logic  in_self;
    logic  rf_req;
    mode_e mode_w;

    // Previous enable level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_n_q <= 1'b1;
        else        en_n_q <= chip_en_n;
    end

    assign ext_start = en_n_q && !chip_en_n && chip_sel;
    assign hold      = chip_en_n && !refresh_n;
    assign mode      = mode_w;

    psram_mode_dec u_dec (
        .chip_en_n (chip_en_n),
        .chip_sel  (chip_sel),
        .out_en_n  (out_en_n),
        .wr_n      (wr_n),
        .refresh_n (refresh_n),
        .in_self   (in_self),
        .mode      (mode_w),
        .dout_en   (dout_en)
    );

    psram_rfsh_sched #(
        .SELF_ENTER  (SELF_ENTER),
        .SELF_PERIOD (SELF_PERIOD)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .in_self (in_self),
        .rf_req  (rf_req)
    );

    psram_row_arb #(
        .ROW_W   (ROW_W),
        .ACT_LEN (ACT_LEN),
        .PEND_W  (PEND_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rf_req     (rf_req),
        .ext_start  (ext_start),
        .ext_row_in (addr_in[ROW_W-1:0]),
        .act_stb    (act_stb),
        .act_ext    (act_ext),
        .act_row    (act_row)
    );
endmodule

// File: rtl/psram_refresh_ctrl_chk.sv
// Checker for the refresh controller: port-level properties checked every
// cycle, attached to every instance of the top by the bind below.
module psram_refresh_ctrl_chk #(
    parameter int ROW_W   = 9,
    parameter int ACT_LEN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en_n,
    input logic             chip_sel,
    input logic             refresh_n,
    input logic [2:0]       mode,
    input logic             dout_en,
    input logic             act_stb,
    input logic             act_ext,
    input logic [ROW_W-1:0] act_row
);
    logic [15:0]      since_act;
    logic [ROW_W-1:0] last_ctr_row;
    logic             have_ctr_row;

    // Ticks since the last activation, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_act <= 16'hFFFF;
        else if (act_stb)         since_act <= 16'd1;
        else if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
    end

    // Last counter row seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ctr_row <= '0;
            have_ctr_row <= 1'b0;
        end else if (act_stb && !act_ext) begin
            last_ctr_row <= act_row;
            have_ctr_row <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !act_stb);

    // R2
    desel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !chip_sel) |-> (mode == 3'd4));

    // R3
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |-> !dout_en);

    // R5
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_stb && !act_ext && have_ctr_row) |-> (act_row == last_ctr_row + 1'b1));

    // R6
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> (since_act >= 16'(ACT_LEN)));

    // R9
    self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> $past(chip_en_n && !refresh_n));
endmodule

bind psram_refresh_ctrl psram_refresh_ctrl_chk #(
    .ROW_W   (ROW_W),
    .ACT_LEN (ACT_LEN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .chip_sel  (chip_sel),
    .refresh_n (refresh_n),
    .mode      (mode),
    .dout_en   (dout_en),
    .act_stb   (act_stb),
    .act_ext   (act_ext),
    .act_row   (act_row)
);

// File: tb/psram_refresh_ctrl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random pin traffic.
module psram_refresh_ctrl_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 17;
    localparam int ROW_W       = 9;
    localparam int ROWS        = 1 << ROW_W;
    localparam int ACT_LEN     = 3;
    localparam int PEND_W      = 2;
    localparam int SELF_ENTER  = 20;
    localparam int SELF_PERIOD = 8;
    localparam int EV_MAX      = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en_n = 1'b1, chip_sel = 1'b1, out_en_n = 1'b1, wr_n = 1'b1, refresh_n = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [2:0] mode;
    logic dout_en, act_stb, act_ext;
    logic [ROW_W-1:0] act_row;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int low_model = 0;
    int ev_n = 0;
    logic [ROW_W-1:0] ev_row [EV_MAX];
    logic             ev_ext [EV_MAX];
    int               ev_cyc [EV_MAX];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_refresh_ctrl #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .ACT_LEN(ACT_LEN), .PEND_W(PEND_W),
        .SELF_ENTER(SELF_ENTER), .SELF_PERIOD(SELF_PERIOD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .chip_sel(chip_sel),
        .out_en_n(out_en_n), .wr_n(wr_n), .refresh_n(refresh_n), .addr_in(addr_in),
        .mode(mode), .dout_en(dout_en), .act_stb(act_stb), .act_ext(act_ext),
        .act_row(act_row)
    );

    // Cycle stamp and spec model of how long refresh has been held.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || !(chip_en_n && !refresh_n)) low_model <= 0;
        else if (low_model < SELF_ENTER)          low_model <= low_model + 1;
    end

    // Activation log, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && act_stb && ev_n < EV_MAX) begin
            ev_row[ev_n] = act_row;
            ev_ext[ev_n] = act_ext;
            ev_cyc[ev_n] = cyc;
            ev_n = ev_n + 1;
        end
    end

    function automatic int exp_mode(logic en_n, logic sel, logic oe_n, logic w_n,
                                    logic rf_n, int lowc);
        if (!en_n) begin
            if (!sel) return 4;
            if (!w_n) return 2;
            if (!oe_n) return 1;
            return 3;
        end
        if (rf_n) return 0;
        return (lowc >= SELF_ENTER) ? 6 : 5;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic park();
        chip_en_n = 1'b1; chip_sel = 1'b1; out_en_n = 1'b1; wr_n = 1'b1; refresh_n = 1'b1;
    endtask

    task automatic chk_mode(input string req);
        #1;
        chk(mode == 3'(exp_mode(chip_en_n, chip_sel, out_en_n, wr_n, refresh_n, low_model)),
            req, int'(mode), exp_mode(chip_en_n, chip_sel, out_en_n, wr_n, refresh_n, low_model));
        chk(dout_en == (exp_mode(chip_en_n, chip_sel, out_en_n, wr_n, refresh_n, low_model) == 1),
            "R3", int'(dout_en), int'(exp_mode(chip_en_n, chip_sel, out_en_n, wr_n, refresh_n, low_model) == 1));
    endtask

    // One external access of n ticks with the given pins.
    task automatic access(input logic sel, input logic oe_n, input logic w_n,
                          input logic [ADDR_W-1:0] a, input int n, input string req);
        step(1);
        chip_en_n = 1'b0; chip_sel = sel; out_en_n = oe_n; wr_n = w_n; addr_in = a;
        chk_mode(req);
        step(n);
        park();
    endtask

    // One refresh pulse, low for one tick.
    task automatic pulse();
        step(1);
        refresh_n = 1'b0;
        chk_mode("R2");
        step(1);
        refresh_n = 1'b1;
    endtask

    int s, r0;
    logic [ROW_W-1:0] ctr_model = '0;

    initial begin
        void'($urandom(32'd20240611));
        park();
        // R1: reset state.
        step(3);
        chk(act_stb == 1'b0, "R1", int'(act_stb), 0);
        chk(mode == 3'd0, "R1", int'(mode), 0);
        chk(dout_en == 1'b0, "R1", int'(dout_en), 0);
        rst_n = 1'b1;
        step(2);
        chk(ev_n == 0, "R1", ev_n, 0);

        // R5: pulse refreshes walk the counter from row 0.
        s = ev_n;
        for (int i = 0; i < 5; i++) begin pulse(); step(5); end
        chk(ev_n - s == 5, "R5", ev_n - s, 5);
        for (int i = 0; i < 5; i++) begin
            chk(ev_ext[s+i] == 1'b0 && ev_row[s+i] == ROW_W'(i), "R5", int'(ev_row[s+i]), i);
        end
        ctr_model = ROW_W'(5);

        // R8: latency from an idle array is two rising edges.
        step(4);
        s = ev_n;
        r0 = cyc;
        refresh_n = 1'b0;
        step(1);
        refresh_n = 1'b1;
        step(4);
        chk(ev_n - s == 1 && ev_cyc[s] - r0 == 2, "R8", ev_cyc[s] - r0, 2);
        ctr_model = ctr_model + 1'b1;

        // R4: row-touch access uses the captured address and leaves the counter.
        s = ev_n;
        access(1'b1, 1'b1, 1'b1, 17'h1A5C3, 4, "R2");
        step(4);
        chk(ev_n - s == 1, "R4", ev_n - s, 1);
        chk(ev_ext[s] == 1'b1 && ev_row[s] == 9'h1C3, "R4", int'(ev_row[s]), 'h1C3);
        // Read and write accesses.
        access(1'b1, 1'b0, 1'b1, 17'h00042, 3, "R2");
        access(1'b1, 1'b0, 1'b0, 17'h1FFFF, 3, "R2");
        step(4);
        chk(ev_n - s == 3, "R4", ev_n - s, 3);
        chk(ev_row[s+1] == 9'h042 && ev_row[s+2] == 9'h1FF, "R4", int'(ev_row[s+2]), 'h1FF);
        // Deselected: no activation, other pins ignored.
        s = ev_n;
        access(1'b0, 1'b0, 1'b0, 17'h00077, 3, "R2");
        access(1'b0, 1'b0, 1'b1, 17'h00078, 3, "R2");
        step(4);
        chk(ev_n == s, "R4", ev_n - s, 0);
        // Counter untouched by all of the above.
        s = ev_n;
        pulse();
        step(4);
        chk(ev_ext[s] == 1'b0 && ev_row[s] == ctr_model, "R4", int'(ev_row[s]), int'(ctr_model));
        ctr_model = ctr_model + 1'b1;

        // R7: two waiting refreshes go ahead of an access started after them.
        step(4);
        s = ev_n;
        refresh_n = 1'b0; step(1);
        refresh_n = 1'b1; step(1);
        refresh_n = 1'b0; step(1);
        refresh_n = 1'b1; chip_en_n = 1'b0; chip_sel = 1'b1; addr_in = 17'h00155;
        step(3);
        park();
        step(12);
        chk(ev_n - s == 3, "R7", ev_n - s, 3);
        chk(!ev_ext[s] && ev_row[s] == ctr_model, "R7", int'(ev_row[s]), int'(ctr_model));
        chk(!ev_ext[s+1] && ev_row[s+1] == ctr_model + 1'b1, "R7", int'(ev_row[s+1]), int'(ctr_model + 1'b1));
        chk(ev_ext[s+2] && ev_row[s+2] == 9'h155, "R7", int'(ev_row[s+2]), 'h155);
        // R6: waiting activations come out exactly ACT_LEN apart.
        chk(ev_cyc[s+1] - ev_cyc[s] == ACT_LEN, "R6", ev_cyc[s+1] - ev_cyc[s], ACT_LEN);
        chk(ev_cyc[s+2] - ev_cyc[s+1] == ACT_LEN, "R6", ev_cyc[s+2] - ev_cyc[s+1], ACT_LEN);

        // R2/R3: seeded random pin traffic against the mode model.
        for (int i = 0; i < 400; i++) begin
            step(1);
            chip_en_n = ($urandom_range(0, 2) != 0);
            chip_sel  = ($urandom_range(0, 3) != 0);
            out_en_n  = $urandom_range(0, 1) != 0;
            wr_n      = $urandom_range(0, 1) != 0;
            refresh_n = ($urandom_range(0, 9) < 3) ? ~refresh_n : refresh_n;
            addr_in   = ADDR_W'($urandom);
            chk_mode("R2");
        end
        park();
        step(30);

        // R9/R10: long held refresh walks every row with a fixed cadence.
        s = ev_n;
        refresh_n = 1'b0;
        for (int j = 0; j < SELF_ENTER + (ROWS + 2) * SELF_PERIOD; j++) begin
            if (j == SELF_ENTER - 1 || j == SELF_ENTER || j == 200) chk_mode("R9");
            step(1);
        end
        refresh_n = 1'b1;
        step(ACT_LEN + 2);
        r0 = ev_n;
        step(5 * SELF_PERIOD);
        chk(ev_n == r0, "R9", ev_n - r0, 0);
        chk(r0 - s >= ROWS + 1, "R10", r0 - s, ROWS + 1);
        begin
            bit seen [ROWS];
            int bad_step = 0, bad_gap = 0, missing = 0;
            for (int k = 0; k < ROWS; k++) seen[k] = 1'b0;
            for (int k = s; k < r0; k++) begin
                seen[ev_row[k]] = 1'b1;
                if (ev_ext[k]) bad_step++;
                if (k > s && ev_row[k] != ev_row[k-1] + 1'b1) bad_step++;
                if (k > s + 1 && ev_cyc[k] - ev_cyc[k-1] != SELF_PERIOD) bad_gap++;
            end
            for (int k = 0; k < ROWS; k++) if (!seen[k]) missing++;
            chk(bad_step == 0, "R5", bad_step, 0);
            chk(bad_gap == 0, "R9", bad_gap, 0);
            chk(missing == 0, "R10", missing, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule